// File: doc/BRIEF.md
# Byte-Serial CRC-16 Generator and Checker

This block computes a 16-bit cyclic redundancy check over packet payloads one byte per clock. It is placed between a byte source and a byte sink. In transmit mode it accumulates the CRC over the payload and then drives the two check bytes that the framer appends after the payload. In receive mode it runs over the payload and the two received check bytes, and then reports whether the packet is intact.

A single enable input turns CRC handling on or off in both directions. A select input chooses the generator polynomial. It picks either the fixed default x^16 + x^12 + x^5 + 1 or a 16-bit polynomial assembled from two byte-wide inputs. The register starts from all ones and takes each byte most significant bit first. No final XOR is applied.

Top module: `crc16_unit`

## Requirements
- R1: While `crcEnable` is 0 at the start byte of a packet, `outValid` and `resultValid` stay 0 for that packet, whatever the values of `polySelect`, `polyLow` and `polyHigh`.
- R2: With `polySelect` at 0 the generator polynomial is 0x1021. The register is seeded with 0xFFFF, bits are taken MSB first and there is no output XOR, so the ASCII string "123456789" gives 0x29B1.
- R3: With `polySelect` at 1 the polynomial is `{polyHigh, polyLow}`. The mode, enable and polynomial are captured on the start byte and held for the rest of the packet.
- R4: In transmit mode (`txMode`=1), `outValid` is 1 in the first cycle after the clock edge that takes the last payload byte, with `outData` carrying CRC bits 15:8. In the next cycle it carries bits 7:0. `outValid` is 0 in the cycle after that.
- R5: In receive mode, `resultValid` pulses for one cycle in the cycle after the edge that takes the last byte (the second check byte). `crcPass` is 1 exactly when the register is 0x0000 after that byte, so a correct appended CRC passes and any corruption fails.
- R6: A byte with `inStart` reseeds the register and begins a new packet, even in the middle of a packet. Bytes with `inValid` but no `inStart` while no packet is open are ignored.
- R7: Input bytes presented during the two append cycles are ignored, including ones that carry `inStart`.
- R8: One byte is absorbed per clock with `inValid` at 1. Cycles with `inValid` at 0 inside a packet leave the CRC unchanged.
- R9: After reset `outValid` and `resultValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| crcEnable | input | 1 | CRC append/check enable, sampled on the start byte |
| polySelect | input | 1 | 0: default polynomial, 1: programmable polynomial |
| polyLow | input | 8 | Programmable polynomial bits 7:0 |
| polyHigh | input | 8 | Programmable polynomial bits 15:8 |
| txMode | input | 1 | 1: transmit (generate), 0: receive (check) |
| inValid | input | 1 | Input byte strobe |
| inStart | input | 1 | Marks the first byte of a packet |
| inEnd | input | 1 | Marks the last byte of a packet |
| inData | input | 8 | Input byte |
| outValid | output | 1 | Appended CRC byte valid |
| outData | output | 8 | Appended CRC byte, high byte first |
| resultValid | output | 1 | One-cycle check-result strobe |
| crcPass | output | 1 | Check result, valid with `resultValid` |

## Verification
A table of packets is run in both directions. The table varies length (including a single byte), byte patterns and polynomials: the default, programmed copies of the default, and unrelated polynomials such as 0x8005, 0xC867 and 0x0001. Comparing transmit bytes against an independent bit-serial model checks both polynomial routing and byte order. Each receive run is done once intact and once with a flipped bit, which separates a true zero-remainder check from a constant result. Directed packets with gaps, mid-packet restarts, stray bytes while idle, bytes during append, a polynomial changed mid-packet and the disabled mode cover reseeding, latching and the cases where input must be ignored.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  typedef struct packed {
    logic seed;      // start byte: reseed register and capture polynomial
    logic absorb;    // fold inData into the register
    logic emitHigh;  // drive upper CRC byte on outData
    logic report;    // latch receive check result
  } crcStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PAYLOAD,
    ST_APPEND_HI,
    ST_APPEND_LO
  } crcState_t;

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        crcEnable,
  input  logic        txMode,
  input  logic        inValid,
  input  logic        inStart,
  input  logic        inEnd,
  output crcStrobes_t strobes,
  output logic        outValid,
  output logic        resultValid
);

  crcState_t state, stateNext;
  logic enLatched, txLatched;
  logic portOpen, startHit, byteHit, lastHit, curEn, curTx;

  assign portOpen = (state == ST_IDLE) || (state == ST_PAYLOAD);
  assign startHit = inValid && inStart && portOpen;
  assign byteHit  = inValid && portOpen && (inStart || state == ST_PAYLOAD);
  assign lastHit  = byteHit && inEnd;
  assign curEn    = inStart ? crcEnable : enLatched;
  assign curTx    = inStart ? txMode : txLatched;

  always_comb begin
    strobes.seed     = startHit;
    strobes.absorb   = byteHit;
    strobes.emitHigh = (state == ST_APPEND_HI);
    strobes.report   = lastHit && curEn && !curTx;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_APPEND_HI: stateNext = ST_APPEND_LO;
      ST_APPEND_LO: stateNext = ST_IDLE;
      default: begin
        if (byteHit) begin
          if (lastHit) stateNext = (curEn && curTx) ? ST_APPEND_HI : ST_IDLE;
          else         stateNext = ST_PAYLOAD;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      enLatched   <= 1'b0;
      txLatched   <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      state       <= stateNext;
      resultValid <= strobes.report;
      if (startHit) begin
        enLatched <= crcEnable;
        txLatched <= txMode;
      end
    end
  end

  assign outValid = (state == ST_APPEND_HI) || (state == ST_APPEND_LO);

  // R4: appended bytes come as a pair
  a_r4_pair_second: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |=> outValid);
  a_r4_pair_ends: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |=> !outValid);
  // R1: no result for a packet started while disabled
  a_r1_no_result_disabled: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> enLatched);
  // R5: results only for receive packets
  a_r5_result_rx_only: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> !txLatched);
  // R7: nothing absorbed while appending
  a_r7_no_absorb_append: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !strobes.absorb);

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int              DATA_W       = 8,
  parameter int              CRC_W        = 16,
  parameter logic [CRC_W-1:0] DEFAULT_POLY = 16'h1021,
  parameter logic [CRC_W-1:0] SEED_VALUE   = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strobes,
  input  logic              polySelect,
  input  logic [DATA_W-1:0] polyLow,
  input  logic [DATA_W-1:0] polyHigh,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              crcPass
);

  localparam int TOP = CRC_W - 1;

  logic [CRC_W-1:0] crcReg, polyReg, livePoly, polyUse, baseVal;
  logic [DATA_W:0][CRC_W-1:0] stage;

  assign livePoly = polySelect ? {polyHigh, polyLow} : DEFAULT_POLY;
  assign polyUse  = strobes.seed ? livePoly : polyReg;
  assign baseVal  = strobes.seed ? SEED_VALUE : crcReg;
  assign stage[0] = baseVal;

  // eight unrolled bit steps, MSB of the byte first
  for (genvar b = 0; b < DATA_W; b++) begin : g_bitStep
    logic feedBit;
    assign feedBit    = stage[b][TOP] ^ inData[DATA_W-1-b];
    assign stage[b+1] = {stage[b][TOP-1:0], 1'b0} ^ (feedBit ? polyUse : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcReg  <= SEED_VALUE;
      polyReg <= DEFAULT_POLY;
      crcPass <= 1'b0;
    end else begin
      if (strobes.seed)   polyReg <= livePoly;
      if (strobes.absorb) crcReg  <= stage[DATA_W];
      if (strobes.report) crcPass <= (stage[DATA_W] == '0);
    end
  end

  assign outData = strobes.emitHigh ? crcReg[TOP -: DATA_W] : crcReg[DATA_W-1:0];

  // R3: polynomial is held between start bytes
  a_r3_poly_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.seed |=> $stable(polyReg));
  // R4: register frozen while the high byte is emitted
  a_r4_crc_frozen: assert property (@(posedge clk) disable iff (!rstN)
    strobes.emitHigh |=> $stable(crcReg));

endmodule

// File: rtl/crc16_unit.sv
module crc16_unit
  import crc16_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CRC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              crcEnable,
  input  logic              polySelect,
  input  logic [DATA_W-1:0] polyLow,
  input  logic [DATA_W-1:0] polyHigh,
  input  logic              txMode,
  input  logic              inValid,
  input  logic              inStart,
  input  logic              inEnd,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              resultValid,
  output logic              crcPass
);

  crcStrobes_t strobes;

  crc16_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .crcEnable  (crcEnable),
    .txMode     (txMode),
    .inValid    (inValid),
    .inStart    (inStart),
    .inEnd      (inEnd),
    .strobes    (strobes),
    .outValid   (outValid),
    .resultValid(resultValid)
  );

  crc16_datapath #(
    .DATA_W(DATA_W),
    .CRC_W (CRC_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .polySelect(polySelect),
    .polyLow   (polyLow),
    .polyHigh  (polyHigh),
    .inData    (inData),
    .outData   (outData),
    .crcPass   (crcPass)
  );

  // R9: quiet outputs right after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!outValid && !resultValid));

endmodule

// File: tb/crc16_unit_test.sv
module crc16_unit_test;

  localparam int CLK_PERIOD = 10;

  // {select(8), poly(16), length(8), firstByte(8), stepByte(8)}
  localparam logic [47:0] VEC [0:5] = '{
    {8'h00, 16'h0000, 8'd4, 8'h00, 8'h11},
    {8'h00, 16'h0000, 8'd1, 8'hA5, 8'h00},
    {8'h01, 16'h8005, 8'd5, 8'h10, 8'h03},
    {8'h01, 16'hC867, 8'd8, 8'hFF, 8'hF1},
    {8'h01, 16'h1021, 8'd3, 8'h31, 8'h01},
    {8'h01, 16'h0001, 8'd6, 8'h80, 8'h40}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic crcEnable = 1'b0, polySelect = 1'b0, txMode = 1'b0;
  logic [7:0] polyLow = 8'h00, polyHigh = 8'h00;
  logic inValid = 1'b0, inStart = 1'b0, inEnd = 1'b0;
  logic [7:0] inData = 8'h00;
  logic outValid, resultValid, crcPass;
  logic [7:0] outData;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] pkt [0:31];
  int restartAt = -1;
  int gapCycles = 0;
  bit changePoly = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_unit uut (
    .clk(clk), .rstN(rstN), .crcEnable(crcEnable), .polySelect(polySelect),
    .polyLow(polyLow), .polyHigh(polyHigh), .txMode(txMode),
    .inValid(inValid), .inStart(inStart), .inEnd(inEnd), .inData(inData),
    .outValid(outValid), .outData(outData), .resultValid(resultValid),
    .crcPass(crcPass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(input int from, input int upto, input logic [15:0] poly);
    logic [15:0] c = 16'hFFFF;
    for (int i = from; i < upto; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ pkt[i][b];
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ poly;
      end
    return c;
  endfunction

  task automatic pushPacket(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inStart = (i == 0) || (i == restartAt);
      inEnd   = (i == n - 1);
      inData  = pkt[i];
      if (gapCycles > 0 && i < n - 1) begin
        @(negedge clk);
        inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
        if (changePoly) polyLow = polyLow ^ 8'h5A;
        repeat (gapCycles - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
  endtask

  task automatic doTx(input int n, input int from, input logic [15:0] poly, input string req);
    logic [15:0] c;
    c = refCrc(from, n, poly);
    txMode = 1'b1;
    pushPacket(n);
    chk({req, " tx hi valid"}, outValid, 1);
    chk({req, " tx hi byte"}, outData, c[15:8]);
    @(negedge clk);
    chk({req, " tx lo valid"}, outValid, 1);
    chk({req, " tx lo byte"}, outData, c[7:0]);
    @(negedge clk);
    chk({req, " tx done"}, outValid, 0);
  endtask

  task automatic doRx(input int n, input logic [15:0] poly, input logic [7:0] flip, input string req);
    logic [15:0] c;
    c = refCrc(0, n, poly);
    pkt[n] = c[15:8];
    pkt[n+1] = c[7:0] ^ flip;
    txMode = 1'b0;
    pushPacket(n + 2);
    chk({req, " rx valid"}, resultValid, 1);
    chk({req, " rx pass"}, crcPass, (flip == 8'h00));
    @(negedge clk);
    chk({req, " rx pulse end"}, resultValid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] poly;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 outValid", outValid, 0);
    chk("R9 resultValid", resultValid, 0);
    rstN = 1'b1;
    crcEnable = 1'b1;
    @(negedge clk);
    chk("R9 outValid after release", outValid, 0);

    // table walk: R2/R3 polynomials, R4 transmit, R5 receive
    for (int v = 0; v < 6; v++) begin
      int len;
      polySelect = VEC[v][40];
      {polyHigh, polyLow} = VEC[v][39:24];
      poly = polySelect ? VEC[v][39:24] : 16'h1021;
      len = int'(VEC[v][23:16]);
      for (int i = 0; i < len; i++) pkt[i] = VEC[v][15:8] + 8'(i) * VEC[v][7:0];
      doTx(len, 0, poly, "R4 R3 table");
      doRx(len, poly, 8'h00, "R5 R2 table intact");
      doRx(len, poly, 8'h10, "R5 table corrupt");
    end

    // R2: known check value for "123456789"
    polySelect = 1'b0;
    for (int i = 0; i < 9; i++) pkt[i] = 8'h31 + 8'(i);
    txMode = 1'b1;
    pushPacket(9);
    chk("R2 check value hi", outData, 8'h29);
    @(negedge clk);
    chk("R2 check value lo", outData, 8'hB1);
    @(negedge clk);

    // R8: gaps inside packet; R3: polynomial changed mid-packet is not used
    polySelect = 1'b1; {polyHigh, polyLow} = 16'h3D65;
    for (int i = 0; i < 5; i++) pkt[i] = 8'hC3 ^ 8'(i * 7);
    gapCycles = 2; changePoly = 1'b1;
    doTx(5, 0, 16'h3D65, "R8 R3 gaps and held poly");
    gapCycles = 0; changePoly = 1'b0;

    // R6: restart mid-packet
    polySelect = 1'b0;
    for (int i = 0; i < 7; i++) pkt[i] = 8'h5C + 8'(i * 3);
    restartAt = 3;
    doTx(7, 3, 16'h1021, "R6 restart");
    restartAt = -1;

    // R6: stray bytes while idle are ignored
    @(negedge clk);
    inValid = 1'b1; inStart = 1'b0; inEnd = 1'b0; inData = 8'hEE;
    @(negedge clk);
    inEnd = 1'b1; inData = 8'h99;
    @(negedge clk);
    inValid = 1'b0; inEnd = 1'b0;
    chk("R6 idle stray no append", outValid, 0);
    @(negedge clk);
    chk("R6 idle stray no result", resultValid, 0);
    for (int i = 0; i < 2; i++) pkt[i] = 8'h42 + 8'(i);
    doTx(2, 0, 16'h1021, "R6 after stray");

    // R7: start byte during append is ignored
    for (int i = 0; i < 3; i++) pkt[i] = 8'h0F << i;
    poly = refCrc(0, 3, 16'h1021);
    txMode = 1'b1;
    pushPacket(3);
    chk("R7 hi byte", outData, poly[15:8]);
    inValid = 1'b1; inStart = 1'b1; inEnd = 1'b1; inData = 8'h77;
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inEnd = 1'b0;
    chk("R7 lo byte", outData, poly[7:0]);
    @(negedge clk);
    chk("R7 no extra append", outValid, 0);

    // R1: disabled, select and polynomial inputs irrelevant
    crcEnable = 1'b0; polySelect = 1'b1; {polyHigh, polyLow} = 16'hBEEF;
    for (int i = 0; i < 3; i++) pkt[i] = 8'h11 * 8'(i + 1);
    txMode = 1'b1;
    pushPacket(3);
    chk("R1 tx no append", outValid, 0);
    @(negedge clk);
    chk("R1 tx no append 2", outValid, 0);
    txMode = 1'b0;
    pushPacket(5);
    chk("R1 rx no result", resultValid, 0);
    @(negedge clk);
    chk("R1 rx no result 2", resultValid, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule